// File: doc/BRIEF.md
# Flash Command Decoder and Status Unit

This block is the command front end of a byte-wide flash array. Every host write arrives as a strobe with an address and a data byte. The block decodes one-cycle commands that take effect at once: the read-mode selects and the status clear. It also decodes two-cycle commands, byte program and sector erase, which first arm a setup state and then consume the next write.

A valid program or erase sequence issues a one-cycle request, with the captured address and data, to an abstract array back end. The block then stays busy until the back end pulses its done input. While the operation runs, the block reports busy through an active-low output and through the ready bit of its status byte.

The status byte keeps three sticky error flags:
- a malformed erase sequence sets them as a sequence error;
- a program or erase aimed at a sector that the lock logic reports as protected sets them as a protection error, and no request is issued.

The flags stay set until the clear command is written. The read-mode output tells the surrounding read path whether to return array data, the status byte or the identifier byte.

Top module: `flash_cmd_unit`

## Requirements
- R1: After reset, readMode is 0 (array), statusByte is 80h, busyN is 1, and progReq and eraseReq are 0.
- R2: Writing 40h or 10h while idle arms a program. The next write raises progReq for exactly one cycle after its edge, with reqAddr and reqData equal to that write's address and data. busyN and statusByte bit 7 read 0 from that cycle until the edge at which beDone is seen high.
- R3: Writing 20h while idle arms an erase. A following write of D0h raises eraseReq for one cycle, with reqAddr equal to the confirm write's address, and the block is busy as in R2.
- R4: In the armed-erase state, a second write whose data is not D0h sets status bits 5 and 4 (status B0h when no other flag is set). It issues no request and returns to idle.
- R5: When sectProt is 1 on the second write of a sequence, no request is issued. For a program, status bits 4 and 1 are set (92h). For an erase with D0h, status bits 5 and 1 are set (A2h).
- R6: The readMode encoding is 0 array, 1 status, 2 identifier. Writing 70h selects 1, 90h selects 2 and FFh selects 0. Any setup write or second write selects 1.
- R7: idByte is 1Fh when rdAddr is 0, EDh when rdAddr is 1, and 00h otherwise.
- R8: Error bits 5, 4 and 1 stay set across later commands and operations. Only a write of 50h while idle clears them, and that write leaves readMode unchanged.
- R9: While busy, writes have no effect: no request, no change of readMode and no change of the error bits.
- R10: In idle, a write of any code other than 40h, 10h, 20h, 70h, 90h, FFh or 50h changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | One-cycle write strobe |
| wrAddr | input | ADDR_W | Address of the write |
| wrData | input | 8 | Command or program data byte |
| sectProt | input | 1 | Lock logic flag: sector of wrAddr is protected |
| beDone | input | 1 | Back end finished the running operation |
| rdAddr | input | ADDR_W | Read address for identifier decode |
| readMode | output | 2 | Read source: 0 array, 1 status, 2 identifier |
| statusByte | output | 8 | Ready (7), sequence (5), program (4), protection (1) |
| idByte | output | 8 | Identifier byte for rdAddr |
| progReq | output | 1 | One-cycle program request |
| eraseReq | output | 1 | One-cycle sector erase request |
| reqAddr | output | ADDR_W | Address for the request |
| reqData | output | 8 | Data byte for a program request |
| busyN | output | 1 | Low while an operation runs |

## Verification
The assertions assume that beDone arrives only while the block is busy, and never in the same cycle as the request pulse. They also assume that sectProt is meaningful only during a write. The bench acts as the back end itself: it raises beDone for a single cycle, some cycles after a request, and issues writes during busy periods only to test that they are ignored. The identifier and status outputs are compared every cycle against a behavioural model driven by the same stimulus.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] CMD_PGM_A   = 8'h40;
  localparam logic [CMD_W-1:0] CMD_PGM_B   = 8'h10;
  localparam logic [CMD_W-1:0] CMD_ERS     = 8'h20;
  localparam logic [CMD_W-1:0] CMD_CONFIRM = 8'hD0;
  localparam logic [CMD_W-1:0] CMD_STATUS  = 8'h70;
  localparam logic [CMD_W-1:0] CMD_CLEAR   = 8'h50;
  localparam logic [CMD_W-1:0] CMD_IDENT   = 8'h90;
  localparam logic [CMD_W-1:0] CMD_ARRAY   = 8'hFF;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_STATUS = 2'd1,
    RD_IDENT  = 2'd2
  } rdMode_e;

  typedef struct packed {
    logic    setSeq;
    logic    setPgm;
    logic    setProt;
    logic    clrErr;
    logic    ldReq;
    logic    ldMode;
    rdMode_e modeVal;
  } dpStrobe_t;
endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CMD_W-1:0] wrData,
  input  logic             sectProt,
  input  logic             beDone,
  output dpStrobe_t        strobe,
  output logic             progReq,
  output logic             eraseReq,
  output logic             ready
);
  typedef enum logic [1:0] {ST_IDLE, ST_PGM_ARMED, ST_ERS_ARMED, ST_BUSY} ctrlState_e;

  ctrlState_e state, nextState;
  logic startPgm, startErs;

  always_comb begin
    strobe    = '0;
    nextState = state;
    startPgm  = 1'b0;
    startErs  = 1'b0;
    unique case (state)
      ST_IDLE: if (wrEn) begin
        unique case (wrData)
          CMD_PGM_A, CMD_PGM_B: begin
            nextState = ST_PGM_ARMED;
            strobe.ldMode = 1'b1; strobe.modeVal = RD_STATUS;
          end
          CMD_ERS: begin
            nextState = ST_ERS_ARMED;
            strobe.ldMode = 1'b1; strobe.modeVal = RD_STATUS;
          end
          CMD_STATUS: begin strobe.ldMode = 1'b1; strobe.modeVal = RD_STATUS; end
          CMD_IDENT:  begin strobe.ldMode = 1'b1; strobe.modeVal = RD_IDENT;  end
          CMD_ARRAY:  begin strobe.ldMode = 1'b1; strobe.modeVal = RD_ARRAY;  end
          CMD_CLEAR:  strobe.clrErr = 1'b1;
          default: ;
        endcase
      end
      ST_PGM_ARMED: if (wrEn) begin
        strobe.ldMode = 1'b1; strobe.modeVal = RD_STATUS;
        if (sectProt) begin
          strobe.setPgm = 1'b1; strobe.setProt = 1'b1;
          nextState = ST_IDLE;
        end else begin
          strobe.ldReq = 1'b1; startPgm = 1'b1;
          nextState = ST_BUSY;
        end
      end
      ST_ERS_ARMED: if (wrEn) begin
        strobe.ldMode = 1'b1; strobe.modeVal = RD_STATUS;
        if (wrData != CMD_CONFIRM) begin
          strobe.setSeq = 1'b1; strobe.setPgm = 1'b1;
          nextState = ST_IDLE;
        end else if (sectProt) begin
          strobe.setSeq = 1'b1; strobe.setProt = 1'b1;
          nextState = ST_IDLE;
        end else begin
          strobe.ldReq = 1'b1; startErs = 1'b1;
          nextState = ST_BUSY;
        end
      end
      ST_BUSY: if (beDone) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      progReq  <= 1'b0;
      eraseReq <= 1'b0;
    end else begin
      state    <= nextState;
      progReq  <= startPgm;
      eraseReq <= startErs;
    end
  end

  assign ready = (state != ST_BUSY);

  // R2: the two requests never coincide
  a_r2_req_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(progReq && eraseReq));
  // R2, R3: a request is always accompanied by busy
  a_r2_req_busy: assert property (@(posedge clk) disable iff (!rstN)
    (progReq || eraseReq) |-> !ready);
  // R9: no new request while an operation is still running
  a_r9_quiet_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && !beDone) |=> !(progReq || eraseReq));
  // R5: a protected second write never yields a request
  a_r5_prot_noreq: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sectProt && state != ST_IDLE && state != ST_BUSY) |=> !(progReq || eraseReq));
endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int               ADDR_W = 19,
  parameter logic [CMD_W-1:0] MFR_ID = 8'h1F,
  parameter logic [CMD_W-1:0] DEV_ID = 8'hED
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              ready,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CMD_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output rdMode_e           modeReg,
  output logic [CMD_W-1:0]  statusByte,
  output logic [CMD_W-1:0]  idByte,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [CMD_W-1:0]  reqData
);
  logic errSeq, errPgm, errProt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errSeq  <= 1'b0;
      errPgm  <= 1'b0;
      errProt <= 1'b0;
      modeReg <= RD_ARRAY;
      reqAddr <= '0;
      reqData <= '0;
    end else begin
      if (strobe.clrErr) begin
        errSeq  <= 1'b0;
        errPgm  <= 1'b0;
        errProt <= 1'b0;
      end else begin
        if (strobe.setSeq)  errSeq  <= 1'b1;
        if (strobe.setPgm)  errPgm  <= 1'b1;
        if (strobe.setProt) errProt <= 1'b1;
      end
      if (strobe.ldMode) modeReg <= strobe.modeVal;
      if (strobe.ldReq) begin
        reqAddr <= wrAddr;
        reqData <= wrData;
      end
    end
  end

  assign statusByte = {ready, 1'b0, errSeq, errPgm, 2'b00, errProt, 1'b0};

  always_comb begin
    if (rdAddr == '0)                  idByte = MFR_ID;
    else if (rdAddr == ADDR_W'(1))     idByte = DEV_ID;
    else                               idByte = '0;
  end

  // R8: error flags are sticky unless a clear is strobed
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[5] && !strobe.clrErr) |=> statusByte[5]);
  // R8: a clear leaves all three flags low
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrErr |=> (statusByte[5:4] == 2'b00 && !statusByte[1]));
  // R6: read mode only moves on a mode load
  a_r6_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ldMode |=> $stable(modeReg));
endmodule

// File: rtl/flash_cmd_unit.sv
module flash_cmd_unit
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W = 19,
  parameter logic [7:0]  MFR_ID = 8'h1F,
  parameter logic [7:0]  DEV_ID = 8'hED
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              sectProt,
  input  logic              beDone,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [1:0]        readMode,
  output logic [7:0]        statusByte,
  output logic [7:0]        idByte,
  output logic              progReq,
  output logic              eraseReq,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        reqData,
  output logic              busyN
);
  dpStrobe_t strobe;
  rdMode_e   modeReg;
  logic      ready;

  flash_cmd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .sectProt(sectProt), .beDone(beDone), .strobe(strobe),
    .progReq(progReq), .eraseReq(eraseReq), .ready(ready)
  );

  flash_cmd_dp #(.ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ready(ready),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .modeReg(modeReg), .statusByte(statusByte), .idByte(idByte),
    .reqAddr(reqAddr), .reqData(reqData)
  );

  assign readMode = modeReg;
  assign busyN    = ready;
endmodule

// File: tb/flash_cmd_unit_tb.sv
module flash_cmd_unit_tb_top;
  localparam int AW = 19;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic sectProt = 1'b0;
  logic beDone = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [1:0] readMode;
  logic [7:0] statusByte, idByte, reqData;
  logic progReq, eraseReq, busyN;
  logic [AW-1:0] reqAddr;

  int checks = 0;
  int fails = 0;
  bit running = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_unit #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sectProt(sectProt), .beDone(beDone), .rdAddr(rdAddr),
    .readMode(readMode), .statusByte(statusByte), .idByte(idByte),
    .progReq(progReq), .eraseReq(eraseReq), .reqAddr(reqAddr),
    .reqData(reqData), .busyN(busyN)
  );

  // behavioural reference model: 0 idle, 1 program armed, 2 erase armed, 3 busy
  int mSt = 0;
  logic [1:0] mMode = 2'd0;
  bit mE5 = 0, mE4 = 0, mE1 = 0, mProg = 0, mErase = 0;
  logic [AW-1:0] mAddr = '0;
  logic [7:0] mData = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mSt <= 0; mMode <= 2'd0; mE5 <= 0; mE4 <= 0; mE1 <= 0;
      mProg <= 0; mErase <= 0;
    end else begin
      mProg <= 0; mErase <= 0;
      if (mSt == 3) begin
        if (beDone) mSt <= 0;
      end else if (wrEn) begin
        if (mSt == 0) begin
          if (wrData == 8'h40 || wrData == 8'h10) begin mSt <= 1; mMode <= 2'd1; end
          else if (wrData == 8'h20) begin mSt <= 2; mMode <= 2'd1; end
          else if (wrData == 8'h70) mMode <= 2'd1;
          else if (wrData == 8'h90) mMode <= 2'd2;
          else if (wrData == 8'hFF) mMode <= 2'd0;
          else if (wrData == 8'h50) begin mE5 <= 0; mE4 <= 0; mE1 <= 0; end
        end else begin
          mMode <= 2'd1;
          mSt <= 0;
          if (mSt == 1) begin
            if (sectProt) begin mE4 <= 1; mE1 <= 1; end
            else begin mProg <= 1; mAddr <= wrAddr; mData <= wrData; mSt <= 3; end
          end else begin
            if (wrData != 8'hD0) begin mE5 <= 1; mE4 <= 1; end
            else if (sectProt) begin mE5 <= 1; mE1 <= 1; end
            else begin mErase <= 1; mAddr <= wrAddr; mSt <= 3; end
          end
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (running) begin
    logic [7:0] expStat, expId;
    expStat = {(mSt != 3), 1'b0, mE5, mE4, 2'b00, mE1, 1'b0};
    expId = (rdAddr == 0) ? 8'h1F : (rdAddr == 1) ? 8'hED : 8'h00;
    check("R6 readMode model", 32'(readMode), 32'(mMode));
    check("R8 statusByte model", 32'(statusByte), 32'(expStat));
    check("R7 idByte model", 32'(idByte), 32'(expId));
    check("R2 progReq model", 32'(progReq), 32'(mProg));
    check("R3 eraseReq model", 32'(eraseReq), 32'(mErase));
    check("R2 busyN model", 32'(busyN), 32'(mSt != 3));
    if (mProg || mErase) check("R2 reqAddr model", 32'(reqAddr), 32'(mAddr));
    if (mProg) check("R2 reqData model", 32'(reqData), 32'(mData));
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input bit prot = 0);
    wrEn = 1'b1; wrAddr = a; wrData = d; sectProt = prot;
    tick();
    wrEn = 1'b0; sectProt = 1'b0;
  endtask

  task automatic finishOp();
    tick(); tick();
    beDone = 1'b1;
    tick();
    beDone = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    running = 1'b1;
    tick();
    // R1 reset state
    check("R1 mode", 32'(readMode), 0);
    check("R1 status", 32'(statusByte), 32'h80);
    check("R1 busyN", 32'(busyN), 1);
    check("R1 req", 32'({progReq, eraseReq}), 0);

    // R6 / R7 identifier mode and read-mode selects
    wr(0, 8'h90);
    check("R6 ident mode", 32'(readMode), 2);
    rdAddr = 0; tick(); check("R7 mfr id", 32'(idByte), 32'h1F);
    rdAddr = 1; tick(); check("R7 dev id", 32'(idByte), 32'hED);
    rdAddr = 5; tick(); check("R7 other id", 32'(idByte), 0);
    wr(0, 8'hFF);
    check("R6 array mode", 32'(readMode), 0);
    wr(0, 8'h70);
    check("R6 status mode", 32'(readMode), 1);
    // R10 unknown codes ignored
    wr(0, 8'h33);
    check("R10 unknown keeps mode", 32'(readMode), 1);
    check("R10 unknown keeps status", 32'(statusByte), 32'h80);
    wr(0, 8'hFF);
    wr(0, 8'hD0);
    check("R10 stray confirm ignored", 32'(readMode), 0);
    check("R10 stray confirm no req", 32'({progReq, eraseReq}), 0);

    // R2 program with 40h
    wr(0, 8'h40);
    check("R6 setup selects status", 32'(readMode), 1);
    wr(19'h12345, 8'hA5);
    check("R2 progReq", 32'(progReq), 1);
    check("R2 reqAddr", 32'(reqAddr), 32'h12345);
    check("R2 reqData", 32'(reqData), 32'hA5);
    check("R2 busy", 32'(busyN), 0);
    check("R2 ready bit", 32'(statusByte[7]), 0);
    // R9 writes during busy ignored
    wr(0, 8'h90);
    check("R2 pulse one cycle", 32'(progReq), 0);
    wr(0, 8'h20);
    wr(0, 8'hD0);
    check("R9 no req while busy", 32'({progReq, eraseReq}), 0);
    check("R9 mode unchanged", 32'(readMode), 1);
    finishOp();
    check("R2 busy released", 32'(busyN), 1);
    check("R2 status ready", 32'(statusByte), 32'h80);

    // R2 program with 10h
    wr(0, 8'h10);
    wr(19'h7FFFF, 8'h3C);
    check("R2 alt progReq", 32'(progReq), 1);
    check("R2 alt reqData", 32'(reqData), 32'h3C);
    finishOp();

    // R3 erase
    wr(0, 8'h20);
    wr(19'h30000, 8'hD0);
    check("R3 eraseReq", 32'(eraseReq), 1);
    check("R3 reqAddr", 32'(reqAddr), 32'h30000);
    check("R3 busy", 32'(busyN), 0);
    finishOp();
    check("R3 idle after done", 32'(busyN), 1);

    // R4 bad confirm
    wr(0, 8'h20);
    wr(19'h10000, 8'h55);
    check("R4 seq error status", 32'(statusByte), 32'hB0);
    check("R4 no req", 32'({progReq, eraseReq}), 0);
    // R8 sticky through a good program and mode change
    wr(0, 8'h90);
    wr(0, 8'h40);
    wr(19'h00100, 8'h11);
    check("R8 op still runs", 32'(progReq), 1);
    finishOp();
    check("R8 sticky status", 32'(statusByte), 32'hB0);
    // R9 clear while busy ignored
    wr(0, 8'h40);
    wr(19'h00200, 8'h22);
    wr(0, 8'h50);
    check("R9 clear ignored when busy", 32'(statusByte[5:4]), 3);
    finishOp();
    wr(0, 8'h90);
    wr(0, 8'h50);
    check("R8 clear", 32'(statusByte), 32'h80);
    check("R8 clear keeps mode", 32'(readMode), 2);

    // R5 protected program and erase
    wr(0, 8'h40);
    wr(19'h70000, 8'h99, 1);
    check("R5 prot program status", 32'(statusByte), 32'h92);
    check("R5 prot program no req", 32'(progReq), 0);
    wr(0, 8'h50);
    wr(0, 8'h20);
    wr(19'h70000, 8'hD0, 1);
    check("R5 prot erase status", 32'(statusByte), 32'hA2);
    check("R5 prot erase no req", 32'(eraseReq), 0);
    check("R5 still idle", 32'(busyN), 1);
    wr(0, 8'h50);
    check("R8 final clear", 32'(statusByte), 32'h80);

    tick(); tick();
    running = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule